// File: doc/BRIEF.md
# Boot Firmware Flash Write Guard

This block holds the 32-bit control and status register that decides whether memory cycles may write to the boot-firmware flash region. A monitor port presents each memory cycle aimed at that region, with its address, its direction and whether it targets BIOS space or feature space. The block answers in the same cycle whether the cycle may proceed, and it returns the address after any top-swap correction. A simple configuration port reads and writes the register at one fixed offset.

Writes are protected in layers. An unprotect bit must be set. An optional system-management qualifier also requires an external in-SMM indication. A lock-enable bit raises a system-management interrupt request whenever the unprotect bit is switched on. A one-shot lock-down bit freezes the policy fields until the next reset. Two sticky status flags are cleared by writing 1. One records writes that were refused. The other records each attempt to switch on the unprotect bit while lock-enable is set. A report-enable bit turns refused writes into interrupt requests as well.

Top module: `fwp_guard`

## Requirements
- R1: The register answers at offset 0xDC. `cfg_rdata` is combinational on `cfg_addr` and reads 0 at any other offset. Bits 31:12, 9 and 3 always read 0. After reset the register reads 0x20, plus bit 2 equal to `strap_espi` and bit 4 equal to `strap_swap` as sampled during reset.
- R2: `mon_allow` is combinational. A read cycle (`mon_write`=0) is always allowed. A write cycle is allowed only when bit 0 is 1 and, if bit 5 is 1, `in_smm` is also 1.
- R3: A configuration write that changes bit 0 from 0 to 1 while bit 1 is already 1 makes `smi_req` high in the next cycle and sets bit 8. Bit 0 still takes the written value. With bit 1 at 0, or with bit 0 already 1, no request is made.
- R4: Bit 7 (lock-down) is set by writing 1 to it. Software writes cannot clear it, and it stays set until reset.
- R5: While bit 7 is 0, bits 1, 4, 5, 6 and 11 take the written value. While bit 7 is 1, writes to these bits have no effect. Bit 0 stays writable in both cases.
- R6: A monitored write cycle that is refused sets bit 10 in the next cycle. Allowed writes and reads leave bit 10 unchanged.
- R7: Bits 8 and 10 are cleared by writing 1 to them. Writing 0 to them has no effect. If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R8: A refused write cycle while bit 11 is 1 makes `smi_req` high for exactly the next cycle. With bit 11 at 0, a refused write makes no request.
- R9: When bit 4 is 1 and `mon_bios` is 1, `mon_addr_out` equals `mon_addr` with bit `SWAP_BIT` (16 by default) inverted. In every other case it equals `mon_addr`. Feature-space cycles are never altered.
- R10: Bit 2 reflects `strap_espi` captured at reset and ignores every software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| strap_espi | input | 1 | Interface-enable strap, captured in reset |
| strap_swap | input | 1 | Top-swap strap, captured in reset |
| in_smm | input | 1 | Processor is in system-management mode |
| mon_valid | input | 1 | A monitored cycle is present |
| mon_write | input | 1 | Monitored cycle is a write |
| mon_bios | input | 1 | 1 for BIOS space, 0 for feature space |
| mon_addr | input | 32 | Monitored cycle address |
| mon_allow | output | 1 | Monitored cycle may proceed |
| mon_addr_out | output | 32 | Address after top-swap correction |
| smi_req | output | 1 | One-cycle interrupt request |

## Verification
The access decision is swept over all sixteen combinations of unprotect, SMM qualifier, in-SMM input and direction. This separates the layered conditions and shows that only refused writes set the write flag. The unprotect transition is tried with the lock bit on and off, and with bit 0 already set, so that the interrupt edge is told apart from the plain level. Top swap is swept over swap on or off, BIOS or feature space and several addresses, including all-ones and all-zeros. Lock-down is tried with a write that would flip every frozen field, and a second reset with opposite straps shows that the strap values are captured.

// File: rtl/fwp_pkg.sv
// Package: bit positions and widths shared by the write-guard block.
// Assumes a 32-bit register; positions matter because software decodes them.
package fwp_pkg;
    localparam int REG_W       = 32;
    localparam int B_UNPROT    = 0;
    localparam int B_SMILOCK   = 1;
    localparam int B_STRAPIF   = 2;
    localparam int B_SWAP      = 4;
    localparam int B_SMMQUAL   = 5;
    localparam int B_BOOTSEL   = 6;
    localparam int B_LOCKDOWN  = 7;
    localparam int B_UNPROTVIO = 8;
    localparam int B_WRVIO     = 10;
    localparam int B_REPORT    = 11;

    // Policy fields carried between the register and the gate.
    typedef struct packed {
        logic unprot;
        logic smm_qual;
        logic swap;
        logic report;
    } fwp_policy_t;
endpackage

// File: rtl/fwp_ctrl_reg.sv
// Module: control/status register with lock-down, write-once and W1C flags.
// Assumes cfg writes land on the rising edge; hardware flag sets win over clears.
module fwp_ctrl_reg
    import fwp_pkg::*;
#(
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] REG_OFFSET = 8'hDC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              strap_espi,
    input  logic              strap_swap,
    input  logic              hw_wr_viol,
    output logic [REG_W-1:0]  ctl_q,
    output fwp_policy_t       policy,
    output logic              unprot_evt
);
    logic hit;
    logic unprot_q, smilock_q, strapif_q, swap_q, smmqual_q;
    logic bootsel_q, lockdown_q, unprotvio_q, wrvio_q, report_q;
    logic free_wr;

    // Decode a software write to this register.
    always_comb begin
        hit      = cfg_wr && (cfg_addr == REG_OFFSET);
        free_wr  = hit && !lockdown_q;
        unprot_evt = hit && cfg_wdata[B_UNPROT] && !unprot_q && smilock_q;
    end

    // Unprotect bit: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)   unprot_q <= 1'b0;
        else if (hit) unprot_q <= cfg_wdata[B_UNPROT];
    end

    // Lockable policy fields; frozen once lock-down is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smilock_q <= 1'b0;
            swap_q    <= strap_swap;
            smmqual_q <= 1'b1;
            bootsel_q <= 1'b0;
            report_q  <= 1'b0;
        end else if (free_wr) begin
            smilock_q <= cfg_wdata[B_SMILOCK];
            swap_q    <= cfg_wdata[B_SWAP];
            smmqual_q <= cfg_wdata[B_SMMQUAL];
            bootsel_q <= cfg_wdata[B_BOOTSEL];
            report_q  <= cfg_wdata[B_REPORT];
        end
    end

    // Strap reflection: captured in reset, read-only after.
    always_ff @(posedge clk) begin
        if (!rst_n) strapif_q <= strap_espi;
    end

    // Lock-down: one-way set.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lockdown_q <= 1'b0;
        else if (hit && cfg_wdata[B_LOCKDOWN]) lockdown_q <= 1'b1;
    end

    // Sticky flags: hardware set has priority over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unprotvio_q <= 1'b0;
            wrvio_q     <= 1'b0;
        end else begin
            unprotvio_q <= unprot_evt |
                           (unprotvio_q & ~(hit & cfg_wdata[B_UNPROTVIO]));
            wrvio_q     <= hw_wr_viol |
                           (wrvio_q & ~(hit & cfg_wdata[B_WRVIO]));
        end
    end

    // Assemble the visible register image and the policy bundle.
    always_comb begin
        ctl_q              = '0;
        ctl_q[B_UNPROT]    = unprot_q;
        ctl_q[B_SMILOCK]   = smilock_q;
        ctl_q[B_STRAPIF]   = strapif_q;
        ctl_q[B_SWAP]      = swap_q;
        ctl_q[B_SMMQUAL]   = smmqual_q;
        ctl_q[B_BOOTSEL]   = bootsel_q;
        ctl_q[B_LOCKDOWN]  = lockdown_q;
        ctl_q[B_UNPROTVIO] = unprotvio_q;
        ctl_q[B_WRVIO]     = wrvio_q;
        ctl_q[B_REPORT]    = report_q;
        policy.unprot      = unprot_q;
        policy.smm_qual    = smmqual_q;
        policy.swap        = swap_q;
        policy.report      = report_q;
    end
endmodule

// File: rtl/fwp_gate.sv
// Module: combinational access decision for monitored flash-range cycles.
// Assumes one cycle per clock on the monitor port; reads are never blocked.
module fwp_gate
    import fwp_pkg::*;
(
    input  logic        mon_valid,
    input  logic        mon_write,
    input  logic        in_smm,
    input  fwp_policy_t policy,
    output logic        allow,
    output logic        wr_viol,
    output logic        report_evt
);
    logic wr_ok;

    // Layered write permission and refusal detection.
    always_comb begin
        wr_ok      = policy.unprot && (!policy.smm_qual || in_smm);
        allow      = !mon_write || wr_ok;
        wr_viol    = mon_valid && mon_write && !wr_ok;
        report_evt = wr_viol && policy.report;
    end
endmodule

// File: rtl/fwp_swap.sv
// Module: top-swap address correction for BIOS-space cycles.
// Assumes SWAP_BIT names the inverted address line; feature space passes through.
module fwp_swap #(
    parameter int ADDR_W   = 32,
    parameter int SWAP_BIT = 16
) (
    input  logic              swap_en,
    input  logic              bios_space,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic active;

    // Correction applies to BIOS space only.
    always_comb active = swap_en && bios_space;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i == SWAP_BIT) begin : g_inv
            // Inverted line.
            always_comb addr_out[i] = addr_in[i] ^ active;
        end else begin : g_pass
            // Untouched line.
            always_comb addr_out[i] = addr_in[i];
        end
    end
endmodule

// File: rtl/fwp_smi.sv
// Module: registers the interrupt request as a one-cycle pulse per event cycle.
// Assumes events are single-cycle strobes from the register and the gate.
module fwp_smi (
    input  logic clk,
    input  logic rst_n,
    input  logic unprot_evt,
    input  logic report_evt,
    output logic smi_req
);
    // One pulse in the cycle after any triggering event.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_req <= 1'b0;
        else        smi_req <= unprot_evt | report_evt;
    end
endmodule

// File: rtl/fwp_guard.sv
// Module: top of the flash write guard; register, gate, swap and request.
// Assumes one register at REG_OFFSET and a monitor that presents one cycle per clock.
module fwp_guard
    import fwp_pkg::*;
#(
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] REG_OFFSET = 8'hDC,
    parameter int                ADDR_W     = 32,
    parameter int                SWAP_BIT   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              strap_espi,
    input  logic              strap_swap,
    input  logic              in_smm,
    input  logic              mon_valid,
    input  logic              mon_write,
    input  logic              mon_bios,
    input  logic [ADDR_W-1:0] mon_addr,
    output logic              mon_allow,
    output logic [ADDR_W-1:0] mon_addr_out,
    output logic              smi_req
);
    logic [REG_W-1:0] ctl_q;
    fwp_policy_t      policy;
    logic             unprot_evt, wr_viol, report_evt;

    fwp_ctrl_reg #(.CFG_AW(CFG_AW), .REG_OFFSET(REG_OFFSET)) u_reg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .strap_espi(strap_espi), .strap_swap(strap_swap),
        .hw_wr_viol(wr_viol), .ctl_q(ctl_q), .policy(policy),
        .unprot_evt(unprot_evt)
    );

    fwp_gate u_gate (
        .mon_valid(mon_valid), .mon_write(mon_write), .in_smm(in_smm),
        .policy(policy), .allow(mon_allow), .wr_viol(wr_viol),
        .report_evt(report_evt)
    );

    fwp_swap #(.ADDR_W(ADDR_W), .SWAP_BIT(SWAP_BIT)) u_swap (
        .swap_en(policy.swap), .bios_space(mon_bios),
        .addr_in(mon_addr), .addr_out(mon_addr_out)
    );

    fwp_smi u_smi (
        .clk(clk), .rst_n(rst_n), .unprot_evt(unprot_evt),
        .report_evt(report_evt), .smi_req(smi_req)
    );

    // Read mux: the register at its offset, zero elsewhere.
    always_comb cfg_rdata = (cfg_addr == REG_OFFSET) ? ctl_q : '0;
endmodule

// File: rtl/fwp_guard_chk.sv
// Module: assertion checker bound to fwp_guard.
// Assumes bit positions from fwp_pkg and the top's internal ctl_q image.
module fwp_guard_chk #(
    parameter int                CFG_AW     = 8,
    parameter logic [CFG_AW-1:0] REG_OFFSET = 8'hDC,
    parameter int                ADDR_W     = 32,
    parameter int                SWAP_BIT   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CFG_AW-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic              in_smm,
    input logic              mon_valid,
    input logic              mon_write,
    input logic              mon_bios,
    input logic [ADDR_W-1:0] mon_addr,
    input logic              mon_allow,
    input logic [ADDR_W-1:0] mon_addr_out,
    input logic              smi_req,
    input logic [31:0]       ctl_q
);
    logic cfg_hit;
    always_comb cfg_hit = cfg_wr && (cfg_addr == REG_OFFSET);

    // R2: reads are never refused.
    a_r2_read_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && !mon_write) |-> mon_allow);

    // R2: protected state refuses writes.
    a_r2_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_write && !ctl_q[0]) |-> !mon_allow);

    // R2: qualifier without in-SMM refuses writes.
    a_r2_smm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_write && ctl_q[5] && !in_smm) |-> !mon_allow);

    // R3: unprotect under lock raises request and flag.
    a_r3_unprot_smi: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_hit && cfg_wdata[0] && !ctl_q[0] && ctl_q[1]) |=> (smi_req && ctl_q[8]));

    // R4: lock-down never clears.
    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |=> ctl_q[7]);

    // R5: frozen fields after lock-down.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |=> $stable({ctl_q[11], ctl_q[6:4], ctl_q[1]}));

    // R6: refused write sets the write flag.
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_write && !mon_allow) |=> ctl_q[10]);

    // R8: every request has a cause in the previous cycle.
    a_r8_smi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req |-> ($past(mon_valid && mon_write && !mon_allow && ctl_q[11]) ||
                     $past(cfg_hit && cfg_wdata[0] && !ctl_q[0] && ctl_q[1])));

    // R9: feature space passes unaltered.
    a_r9_feature_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && !mon_bios) |-> (mon_addr_out == mon_addr));

    // R9: swapped BIOS cycles differ in exactly the swap line.
    a_r9_swap_one: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_valid && mon_bios && ctl_q[4]) |->
        ($countones(mon_addr_out ^ mon_addr) == 1 && mon_addr_out[SWAP_BIT] != mon_addr[SWAP_BIT]));

    // R10: strap bit steady outside reset.
    a_r10_strap_ro: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ctl_q[2]));
endmodule

bind fwp_guard fwp_guard_chk #(
    .CFG_AW(CFG_AW), .REG_OFFSET(REG_OFFSET), .ADDR_W(ADDR_W), .SWAP_BIT(SWAP_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_smm(in_smm), .mon_valid(mon_valid),
    .mon_write(mon_write), .mon_bios(mon_bios), .mon_addr(mon_addr),
    .mon_allow(mon_allow), .mon_addr_out(mon_addr_out), .smi_req(smi_req),
    .ctl_q(ctl_q)
);

// File: tb/fwp_guard_tb.sv
module fwp_guard_tb;
    localparam logic [7:0] OFS = 8'hDC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = OFS;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        strap_espi = 1'b1;
    logic        strap_swap = 1'b0;
    logic        in_smm = 1'b0;
    logic        mon_valid = 1'b0;
    logic        mon_write = 1'b0;
    logic        mon_bios = 1'b0;
    logic [31:0] mon_addr = '0;
    logic        mon_allow;
    logic [31:0] mon_addr_out;
    logic        smi_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fwp_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .strap_espi(strap_espi),
        .strap_swap(strap_swap), .in_smm(in_smm), .mon_valid(mon_valid),
        .mon_write(mon_write), .mon_bios(mon_bios), .mon_addr(mon_addr),
        .mon_allow(mon_allow), .mon_addr_out(mon_addr_out), .smi_req(smi_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic espi, input logic swp);
        @(negedge clk);
        rst_n = 1'b0; strap_espi = espi; strap_swap = swp;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write at a negedge; returns at the next negedge with results visible.
    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = OFS; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [31:0] d);
        cfg_addr = OFS; #1; d = cfg_rdata;
    endtask

    // Present one monitored cycle; check combinational outputs mid-cycle.
    task automatic mon_cycle(input logic w, input logic b, input logic [31:0] a,
                             output logic allow, output logic [31:0] aout);
        @(negedge clk);
        mon_valid = 1'b1; mon_write = w; mon_bios = b; mon_addr = a;
        #1; allow = mon_allow; aout = mon_addr_out;
        @(negedge clk);
        mon_valid = 1'b0; mon_write = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd, aout;
        logic al;

        // R1 R10: reset image with straps espi=1 swap=0.
        do_reset(1'b1, 1'b0);
        reg_read(rd);
        check("R1 reset image", rd, 32'h24);
        cfg_addr = 8'h40; #1;
        check("R1 other offset", cfg_rdata, 32'h0);
        cfg_addr = OFS;
        check("R1 no smi at reset", {31'b0, smi_req}, 32'h0);

        // R5: writable before lock-down; R1 reserved bits stay zero.
        cfg_write(32'hFFFF_FF7F);
        reg_read(rd);
        check("R5 R1 open write", rd, 32'h877);
        check("R3 no smi without prior lock", {31'b0, smi_req}, 32'h0);

        // R10: bit 2 ignores a write of 0.
        cfg_write(32'h0);
        reg_read(rd);
        check("R10 strap ro", rd, 32'h4);

        // R2 R6 R8: sweep unprotect, qualifier, in-SMM, direction.
        for (int k = 0; k < 16; k++) begin
            logic wpd, qual, smm, wr, exp_allow;
            wpd = k[0]; qual = k[1]; smm = k[2]; wr = k[3];
            cfg_write(32'h500 | (32'(qual) << 5) | 32'(wpd));
            in_smm = smm;
            exp_allow = !wr || (wpd && (!qual || smm));
            mon_cycle(wr, 1'b1, 32'h0001_0000, al, aout);
            check("R2 allow sweep", {31'b0, al}, {31'b0, exp_allow});
            reg_read(rd);
            check("R6 flag on refusal only", {31'b0, rd[10]}, {31'b0, !exp_allow});
            check("R8 no smi when report off", {31'b0, smi_req}, 32'h0);
        end
        in_smm = 1'b0;

        // R3: unprotect under lock.
        cfg_write(32'h502);
        cfg_write(32'h3);
        check("R3 smi pulse", {31'b0, smi_req}, 32'h1);
        reg_read(rd);
        check("R3 flag set", rd, 32'h107);
        @(negedge clk);
        check("R3 pulse one cycle", {31'b0, smi_req}, 32'h0);
        cfg_write(32'h3);
        check("R3 no smi when already set", {31'b0, smi_req}, 32'h0);

        // R7: W1C on bit 8.
        cfg_write(32'h103);
        reg_read(rd);
        check("R7 clear bit8", rd, 32'h7);

        // R8: refused write with reporting on.
        cfg_write(32'h800);
        mon_cycle(1'b1, 1'b1, 32'h0, al, aout);
        check("R8 smi on refusal", {31'b0, smi_req}, 32'h1);
        reg_read(rd);
        check("R6 flag after refusal", rd, 32'hC04);
        @(negedge clk);
        check("R8 one cycle", {31'b0, smi_req}, 32'h0);

        // R7: write 0 to flag leaves it set.
        cfg_write(32'h800);
        reg_read(rd);
        check("R7 write0 no effect", rd, 32'hC04);

        // R7: clear and hardware set in same cycle; set wins.
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 32'hC00;
        mon_valid = 1'b1; mon_write = 1'b1; mon_bios = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; mon_valid = 1'b0; mon_write = 1'b0;
        reg_read(rd);
        check("R7 set wins", rd, 32'hC04);
        cfg_write(32'hC00);
        reg_read(rd);
        check("R7 clear bit10", rd, 32'h804);

        // R9: swap sweep.
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 2; b++) begin
                for (int j = 0; j < 4; j++) begin
                    logic [31:0] a, e;
                    case (j)
                        0: a = 32'h0000_0000;
                        1: a = 32'hFFFF_FFFF;
                        2: a = 32'h0001_2345;
                        default: a = 32'h00FE_0000;
                    endcase
                    if (j == 0) cfg_write(32'(s) << 4);
                    e = (s == 1 && b == 1) ? (a ^ 32'h0001_0000) : a;
                    mon_cycle(1'b0, b[0], a, al, aout);
                    check("R9 swap sweep", aout, e);
                end
            end
        end

        // R4 R5: lock-down freezes policy; bit 0 still free.
        cfg_write(32'h880);
        reg_read(rd);
        check("R4 lock set", rd, 32'h884);
        cfg_write(32'h73);
        reg_read(rd);
        check("R5 R4 frozen fields", rd, 32'h885);
        check("R3 no smi lock off", {31'b0, smi_req}, 32'h0);

        // R1 R10 R4: second reset with opposite straps.
        do_reset(1'b0, 1'b1);
        reg_read(rd);
        check("R1 R10 R4 reset image 2", rd, 32'h30);
        mon_cycle(1'b0, 1'b1, 32'h0, al, aout);
        check("R9 strap swap active", aout, 32'h0001_0000);

        finish_run();
    end
endmodule